// File: doc/BRIEF.md
# Prioritized vectored interrupt controller

This block sits beside a single DSP core and decides which interrupt the core should take next. It gathers six active-low external request pins and seven single-cycle event strobes from on-chip units: power-down, timer, byte DMA, and transmit and receive for two serial ports. It ranks them on a fixed twelve-level ladder and presents the code-memory vector of the winner to the core's sequencer.

Software programs three registers through write strobes. The first is a per-source enable mask. The second is a configuration word that picks edge or level sensing for three of the pins, and that decides whether the second serial port or two of the pins own the two shared priority levels. The third is a global service enable.

The core answers a presented vector with a one-cycle acknowledge. The acknowledge retires a latched request. A level request stays up for as long as its pin is held low. A separate wake output tells an idling core that an enabled request is waiting.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Priority, highest first, with the vector shown on `vector_o`: reset 0x0000, power-down 0x002C, IRQ2 pin 0x0004, IRQL1 pin 0x0008, IRQL0 pin 0x000C, serial 0 transmit 0x0010, serial 0 receive 0x0014, IRQE pin 0x0018, byte DMA 0x001C, serial 1 transmit or IRQ1 pin 0x0020, serial 1 receive or IRQ0 pin 0x0024, timer 0x0028. `req_o` is high whenever any level is presented, and `vector_o` is 0 when none is.
- R2: After reset the reset level is presented (`req_o`=1, vector 0x0000) until it is acknowledged. Reset clears the mask, the configuration word and the global enable, so after that first acknowledge no pin activity produces a request.
- R3: A maskable level is presented only if its `mask_wdata_i` bit is 1. The bit order, from bit 0 to bit 9, is: IRQ2, IRQL1, IRQL0, serial 0 transmit, serial 0 receive, IRQE, byte DMA, level 0x0020, level 0x0024, timer.
- R4: While the global enable is 0, only reset and power-down are presented.
- R5: A high strobe on `pwrdn_i` latches a power-down request. That request ignores both the mask and the global enable, and it clears only when it is acknowledged.
- R6: IRQL0 and IRQL1 are level-sensitive. Each is pending only while its pin is low, and it is never latched or cleared by an acknowledge.
- R7: IRQE latches on a falling edge of its pin. An acknowledge of vector 0x0018 clears the latch. A pin that stays low after the acknowledge does not re-raise the request; the next request needs a new falling edge.
- R8: Configuration bits 2, 1 and 0 select edge sensing (1) or level sensing (0) for the IRQ2, IRQ1 and IRQ0 pins respectively. An edge-mode request clears on acknowledge even while the pin stays low. A level-mode request survives acknowledge.
- R9: Configuration bit 3 set to 1 gives levels 0x0020 and 0x0024 to the serial 1 transmit and receive strobes and ignores the IRQ1 and IRQ0 pins. Bit 3 set to 0 gives those levels to the pins and ignores the serial 1 strobes.
- R10: `ack_i`, taken while `req_o` is high, clears only the latch of the level being presented. The next pending level is then presented.
- R11: `wake_o` is high when reset, power-down or any pending request whose mask bit is 1 is waiting. It does not depend on the global enable.
- R12: A one-cycle high strobe on any on-chip event input latches its request until that request is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq2_ni | input | 1 | IRQ2 pin, active low, edge or level by configuration |
| irql1_ni | input | 1 | IRQL1 pin, active low, level |
| irql0_ni | input | 1 | IRQL0 pin, active low, level |
| irqe_ni | input | 1 | IRQE pin, active low, falling edge |
| irq1_ni | input | 1 | IRQ1 pin, active low, edge or level by configuration |
| irq0_ni | input | 1 | IRQ0 pin, active low, edge or level by configuration |
| pwrdn_i | input | 1 | Power-down request strobe |
| sp0_tx_i | input | 1 | Serial 0 transmit strobe |
| sp0_rx_i | input | 1 | Serial 0 receive strobe |
| bdma_i | input | 1 | Byte DMA strobe |
| sp1_tx_i | input | 1 | Serial 1 transmit strobe |
| sp1_rx_i | input | 1 | Serial 1 receive strobe |
| timer_i | input | 1 | Timer strobe |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 10 | Mask value, 1 = enabled |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4 | Configuration value |
| ena_we_i | input | 1 | Global enable write strobe |
| ena_wdata_i | input | 1 | Global enable value |
| ack_i | input | 1 | Core acknowledge of the presented vector |
| req_o | output | 1 | A vector is presented |
| vector_o | output | 14 | Vector address of the presented level |
| wake_o | output | 1 | Enabled request waiting, for idle exit |

## Verification
The bench builds the block with its default two-stage pin synchronizer. With that setting a pin change becomes visible within three clocks, so each pin-driven check can sample after a short fixed settle time. The bench also drives edge and level behaviour on the same pin, by rewriting the configuration word between an acknowledge and the next sample. That exposes both the latch-retire path and the pass-through level path. It also makes the two shared levels switch owner, so the bench can confirm that the source not selected has no effect on `req_o`.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int N_LVL  = 12;
  localparam int N_MASK = N_LVL - 2;
  localparam int IDX_W  = $clog2(N_LVL);
  localparam int VEC_W  = 14;
  localparam int N_PIN  = 6;
  localparam int CFG_W  = 4;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [IDX_W-1:0] idx_t;

  // level 0 reset, level 1 power-down, levels 2.. step by 4 from 0x0004
  function automatic vec_t vec_of(idx_t idx);
    if (idx == '0) return '0;
    if (idx == idx_t'(1)) return vec_t'(14'h002C);
    return vec_t'((int'(idx) - 1) * 4);
  endfunction
endpackage

// File: rtl/vec_irq_sync.sv
module vec_irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter bit RST_V  = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [W-1:0] stg_q [STAGES];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int k = 0; k < STAGES; k++) stg_q[k] <= {W{RST_V}};
        end else begin
          stg_q[0] <= d_i;
          for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
        end
      end
      assign q_o = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/vec_irq_pend.sv
module vec_irq_pend #(
  parameter int N = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] lvl_mode_i,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] latch_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) latch_q[g] <= 1'b0;
      else         latch_q[g] <= (latch_q[g] & ~clr_i[g]) | set_i[g]; // new event wins
    end
    assign pend_o[g] = lvl_mode_i[g] ? lvl_i[g] : latch_q[g];
  end
endmodule

// File: rtl/vec_irq_prio.sv
module vec_irq_prio #(
  parameter int N     = 12,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq2_ni,
  input  logic              irql1_ni,
  input  logic              irql0_ni,
  input  logic              irqe_ni,
  input  logic              irq1_ni,
  input  logic              irq0_ni,
  input  logic              pwrdn_i,
  input  logic              sp0_tx_i,
  input  logic              sp0_rx_i,
  input  logic              bdma_i,
  input  logic              sp1_tx_i,
  input  logic              sp1_rx_i,
  input  logic              timer_i,
  input  logic              mask_we_i,
  input  logic [N_MASK-1:0] mask_wdata_i,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              ena_we_i,
  input  logic              ena_wdata_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic              wake_o
);
  localparam int P_IRQ2 = 0, P_IRQL1 = 1, P_IRQL0 = 2, P_IRQE = 3, P_IRQ1 = 4, P_IRQ0 = 5;

  logic [N_MASK-1:0] mask_q;
  logic [CFG_W-1:0]  cfg_q;
  logic              ena_q;
  logic              boot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      cfg_q  <= '0;
      ena_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      if (cfg_we_i)  cfg_q  <= cfg_wdata_i;
      if (ena_we_i)  ena_q  <= ena_wdata_i;
    end
  end

  // pin synchronizer and falling-edge detect
  logic [N_PIN-1:0] pin_n, pin_s_n, pin_prev_n, pin_act, pin_fall;
  assign pin_n = {irq0_ni, irq1_ni, irqe_ni, irql0_ni, irql1_ni, irq2_ni};

  vec_irq_sync #(.W(N_PIN), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_n),
    .q_o   (pin_s_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_prev_n <= '1;
    else         pin_prev_n <= pin_s_n;
  end

  assign pin_act  = ~pin_s_n;
  assign pin_fall = pin_prev_n & ~pin_s_n;

  // per-level source wiring
  logic [N_LVL-1:0] set_ev, lvl_mode, lvl_in, clr, pend, pres;
  logic             sp1_sel;
  assign sp1_sel = cfg_q[3];

  always_comb begin
    set_ev   = '0;
    lvl_mode = '0;
    lvl_in   = '0;
    lvl_mode[0]  = 1'b1;
    set_ev[1]    = pwrdn_i;
    lvl_mode[2]  = ~cfg_q[2];
    lvl_in[2]    = pin_act[P_IRQ2];
    set_ev[2]    = cfg_q[2] & pin_fall[P_IRQ2];
    lvl_mode[3]  = 1'b1;
    lvl_in[3]    = pin_act[P_IRQL1];
    lvl_mode[4]  = 1'b1;
    lvl_in[4]    = pin_act[P_IRQL0];
    set_ev[5]    = sp0_tx_i;
    set_ev[6]    = sp0_rx_i;
    set_ev[7]    = pin_fall[P_IRQE];
    set_ev[8]    = bdma_i;
    lvl_mode[9]  = ~sp1_sel & ~cfg_q[1];
    lvl_in[9]    = pin_act[P_IRQ1];
    set_ev[9]    = sp1_sel ? sp1_tx_i : (cfg_q[1] & pin_fall[P_IRQ1]);
    lvl_mode[10] = ~sp1_sel & ~cfg_q[0];
    lvl_in[10]   = pin_act[P_IRQ0];
    set_ev[10]   = sp1_sel ? sp1_rx_i : (cfg_q[0] & pin_fall[P_IRQ0]);
    set_ev[11]   = timer_i;
  end

  vec_irq_pend #(.N(N_LVL)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_ev),
    .clr_i     (clr),
    .lvl_mode_i(lvl_mode),
    .lvl_i     (lvl_in),
    .pend_o    (pend)
  );

  assign pres[0] = boot_q;
  assign pres[1] = pend[1];
  assign pres[N_LVL-1:2] = pend[N_LVL-1:2] & mask_q & {N_MASK{ena_q}};

  logic win_valid;
  idx_t win_idx;

  vec_irq_prio #(.N(N_LVL), .IDX_W(IDX_W)) u_prio (
    .req_i  (pres),
    .valid_o(win_valid),
    .idx_o  (win_idx)
  );

  always_comb begin
    clr = '0;
    if (ack_i && win_valid) clr[win_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     boot_q <= 1'b1;
    else if (clr[0]) boot_q <= 1'b0;
  end

  assign req_o    = win_valid;
  assign vector_o = win_valid ? vec_of(win_idx) : '0;
  assign wake_o   = boot_q | pend[1] | (|(pend[N_LVL-1:2] & mask_q));
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk
  import vec_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_i,
  input logic              req_o,
  input logic [VEC_W-1:0]  vector_o,
  input logic              wake_o,
  input logic [N_MASK-1:0] mask_q,
  input logic              ena_q
);
  logic maskable, mbit;
  int   mpos;
  always_comb begin
    maskable = (vector_o >= VEC_W'(14'h0004)) && (vector_o <= VEC_W'(14'h0028));
    mpos     = int'(vector_o >> 2) - 1;
    mbit     = (maskable && mpos >= 0 && mpos < N_MASK) ? mask_q[mpos] : 1'b0;
  end

  AST_VEC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (vector_o[1:0] == 2'b00 && vector_o <= VEC_W'(14'h002C))); // R1

  AST_MASK_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && maskable) |-> (mbit && ena_q)); // R3

  AST_OFF_ONLY_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ena_q) |-> (vector_o == '0 || vector_o == VEC_W'(14'h002C))); // R4

  AST_PWR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && vector_o == VEC_W'(14'h002C) && !ack_i) |=>
      (req_o && vector_o == VEC_W'(14'h002C))); // R5

  AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && vector_o == VEC_W'(14'h0018) && !ack_i) |=>
      (req_o || !ena_q || !mask_q[5])); // R7

  AST_WAKE_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> wake_o); // R11
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ack_i   (ack_i),
  .req_o   (req_o),
  .vector_o(vector_o),
  .wake_o  (wake_o),
  .mask_q  (mask_q),
  .ena_q   (ena_q)
);

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [5:0]  low;    // 1 = pin driven low; bit0 irq2,1 irql1,2 irql0,3 irqe,4 irq1,5 irq0
  logic [6:0]  pulse;  // bit0 pwrdn,1 sp0tx,2 sp0rx,3 bdma,4 sp1tx,5 sp1rx,6 timer
  logic        mask_we, cfg_we, ena_we, ena_wd, ack;
  logic [9:0]  mask_wd;
  logic [3:0]  cfg_wd;
  logic        req, wake;
  logic [13:0] vec;

  vec_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .irq2_ni(~low[0]), .irql1_ni(~low[1]), .irql0_ni(~low[2]),
    .irqe_ni(~low[3]), .irq1_ni(~low[4]), .irq0_ni(~low[5]),
    .pwrdn_i(pulse[0]), .sp0_tx_i(pulse[1]), .sp0_rx_i(pulse[2]), .bdma_i(pulse[3]),
    .sp1_tx_i(pulse[4]), .sp1_rx_i(pulse[5]), .timer_i(pulse[6]),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wd),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
    .ena_we_i(ena_we), .ena_wdata_i(ena_wd),
    .ack_i(ack), .req_o(req), .vector_o(vec), .wake_o(wake)
  );

  typedef struct packed {
    logic [9:0]  mask;
    logic [3:0]  cfg;
    logic        ena;
    logic [5:0]  low;
    logic [6:0]  pulse;
    logic        exp_req;
    logic [13:0] exp_vec;
  } row_t;

  localparam int NROW = 13;
  localparam row_t TBL [NROW] = '{
    '{10'h3FF, 4'h0, 1'b1, 6'b000100, 7'b0000000, 1'b1, 14'h000C}, // R6
    '{10'h3FF, 4'h0, 1'b1, 6'b000000, 7'b1000000, 1'b1, 14'h0028}, // R12
    '{10'h3FF, 4'h0, 1'b1, 6'b000001, 7'b1000000, 1'b1, 14'h0004}, // R1
    '{10'h3FF, 4'h0, 1'b0, 6'b000010, 7'b0000000, 1'b0, 14'h0000}, // R4
    '{10'h3FD, 4'h0, 1'b1, 6'b000110, 7'b0000000, 1'b1, 14'h000C}, // R3
    '{10'h000, 4'h0, 1'b0, 6'b000001, 7'b0000001, 1'b1, 14'h002C}, // R5
    '{10'h3FF, 4'h8, 1'b1, 6'b010000, 7'b0000000, 1'b0, 14'h0000}, // R9
    '{10'h3FF, 4'h8, 1'b1, 6'b000000, 7'b0010000, 1'b1, 14'h0020}, // R9
    '{10'h3FF, 4'h0, 1'b1, 6'b000000, 7'b0100000, 1'b0, 14'h0000}, // R9
    '{10'h3FF, 4'h0, 1'b1, 6'b100000, 7'b0000000, 1'b1, 14'h0024}, // R8
    '{10'h3FF, 4'h0, 1'b1, 6'b001000, 7'b0000010, 1'b1, 14'h0010}, // R1
    '{10'h3FF, 4'h0, 1'b1, 6'b001000, 7'b0001000, 1'b1, 14'h0018}, // R1
    '{10'h3FF, 4'h0, 1'b1, 6'b000000, 7'b0001100, 1'b1, 14'h0014}  // R1
  };
  localparam string TAGS [NROW] = '{"R6","R12","R1","R4","R3","R5","R9","R9","R9","R8","R1","R1","R1"};

  int n_chk = 0;
  int n_bad = 0;

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic e_req, input logic [13:0] e_vec);
    n_chk++;
    if (req !== e_req || (e_req && vec !== e_vec)) begin
      n_bad++;
      $display("FAIL %s: req=%0b vec=0x%04h expected req=%0b vec=0x%04h", tag, req, vec, e_req, e_vec);
    end
  endtask

  task automatic chk_wake(input string tag, input logic e);
    n_chk++;
    if (wake !== e) begin
      n_bad++;
      $display("FAIL %s: wake=%0b expected %0b", tag, wake, e);
    end
  endtask

  task automatic wr_mask(input logic [9:0] v);
    mask_wd = v; mask_we = 1'b1; cyc(1); mask_we = 1'b0;
  endtask
  task automatic wr_cfg(input logic [3:0] v);
    cfg_wd = v; cfg_we = 1'b1; cyc(1); cfg_we = 1'b0;
  endtask
  task automatic wr_ena(input logic v);
    ena_wd = v; ena_we = 1'b1; cyc(1); ena_we = 1'b0;
  endtask
  task automatic do_ack();
    ack = 1'b1; cyc(1); ack = 1'b0; cyc(1);
  endtask
  task automatic strobe(input logic [6:0] p);
    pulse = p; cyc(1); pulse = '0;
  endtask
  task automatic cleanup();
    low = '0; pulse = '0;
    wr_mask(10'h3FF); wr_ena(1'b1);
    cyc(5);
    for (int i = 0; i < 20; i++) if (req) do_ack();
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    low = '0; pulse = '0; mask_we = 0; cfg_we = 0; ena_we = 0; ack = 0;
    mask_wd = '0; cfg_wd = '0; ena_wd = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R2: reset vector presented after reset
    chk("R2 reset vector", 1'b1, 14'h0000);
    chk_wake("R2 reset wake", 1'b1);
    do_ack();
    chk("R2 reset acked", 1'b0, 14'h0000);
    low[2] = 1'b1; cyc(6);
    chk("R2 masked after reset", 1'b0, 14'h0000);
    chk_wake("R2 no wake when masked", 1'b0);
    low = '0;

    for (int r = 0; r < NROW; r++) begin
      cleanup();
      wr_cfg(TBL[r].cfg);
      wr_mask(TBL[r].mask);
      wr_ena(TBL[r].ena);
      low = TBL[r].low;
      strobe(TBL[r].pulse);
      cyc(6);
      chk(TAGS[r], TBL[r].exp_req, TBL[r].exp_vec);
    end

    // R6: level request drops with pin
    cleanup(); wr_cfg(4'h0);
    low[1] = 1'b1; cyc(6);
    chk("R6 irql1 low", 1'b1, 14'h0008);
    do_ack();
    chk("R6 irql1 survives ack", 1'b1, 14'h0008);
    low[1] = 1'b0; cyc(6);
    chk("R6 irql1 released", 1'b0, 14'h0000);

    // R7: edge latch, no re-trigger while held
    cleanup();
    low[3] = 1'b1; cyc(6);
    chk("R7 irqe edge", 1'b1, 14'h0018);
    do_ack(); cyc(4);
    chk("R7 held low after ack", 1'b0, 14'h0000);
    low[3] = 1'b0; cyc(5); low[3] = 1'b1; cyc(6);
    chk("R7 second edge", 1'b1, 14'h0018);

    // R8: irq2 edge vs level
    cleanup(); wr_cfg(4'b0100);
    low[0] = 1'b1; cyc(6);
    chk("R8 irq2 edge", 1'b1, 14'h0004);
    do_ack(); cyc(2);
    chk("R8 irq2 edge retired", 1'b0, 14'h0000);
    wr_cfg(4'b0000); cyc(1);
    chk("R8 irq2 level", 1'b1, 14'h0004);
    do_ack();
    chk("R8 irq2 level survives ack", 1'b1, 14'h0004);

    // R10: ack retires only presented level
    cleanup(); wr_cfg(4'h0);
    low[3] = 1'b1; strobe(7'b1000000); cyc(6);
    chk("R10 first", 1'b1, 14'h0018);
    do_ack();
    chk("R10 next", 1'b1, 14'h0028);
    do_ack();
    chk("R10 empty", 1'b0, 14'h0000);

    // R11: wake independent of global enable, gated by mask
    cleanup();
    wr_mask(10'h004); wr_ena(1'b0);
    low[2] = 1'b1; cyc(6);
    chk("R11 disabled no req", 1'b0, 14'h0000);
    chk_wake("R11 wake with enable off", 1'b1);
    wr_mask(10'h000); cyc(1);
    chk_wake("R11 masked no wake", 1'b0);

    // R5: power-down beats maskable, cleared by ack
    cleanup();
    low[0] = 1'b1; strobe(7'b0000001); cyc(6);
    chk("R5 pwrdn first", 1'b1, 14'h002C);
    do_ack();
    chk("R5 pwrdn retired", 1'b1, 14'h0004);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule